// File: doc/BRIEF.md
# Latency-Hiding Warp Scheduler

This block holds the state of every resident warp on one compute unit and, in each cycle, picks one warp that can run and issues its next instruction to one of four execution ports. A warp is a group of 32 threads that execute the same instruction together. A block of threads is mapped onto the warp pool when it is launched. The instruction stream is outside this block: for each warp, the surrounding logic presents whether the next instruction has its operands, the instruction's class, and whether that instruction is the warp's last one.

A warp that issues a global load is parked in a sleeping state. The scheduler skips it at once and picks another eligible warp in the very next cycle, with no cycle spent on switching, because no warp state has to be moved. When the memory system reports that the load for a sleeping warp has completed, the warp becomes eligible again. When every warp of the block has issued its final instruction, the block is reported as retired for one cycle and the scheduler accepts a new launch.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset no warp is live: `busy_o`, `iss_valid_o`, `retired_o` and `ldc_err_o` are all 0, and nothing issues whatever the per-warp inputs are.
- R2: A launch while `busy_o` is 0 makes warps 0 to ceil(threads/32)-1 active and sets `busy_o` from the next cycle; the other warps stay idle and never issue. A launch while `busy_o` is 1 is ignored.
- R3: A warp issues only when it is active (launched, not sleeping, not finished) and its `wv_i` bit (operands available) is 1; otherwise `iss_valid_o` stays 0.
- R4: Issuing an instruction of class 2 (load/store) without the last-instruction flag puts the warp to sleep from the next cycle; a sleeping warp is never issued.
- R5: In any cycle in which at least one warp is eligible, an instruction issues in that same cycle; after a load issue another eligible warp issues in the following cycle.
- R6: Among eligible warps the choice is round-robin, starting at the warp after the one issued most recently; after reset the search starts at warp 0.
- R7: Class codes are 0 integer, 1 floating point, 2 load/store, 3 special function; `iss_cls_o` carries the issued warp's class, and a warp is eligible only while bit `cls` of `port_rdy_i` is 1.
- R8: A load completion naming a sleeping warp makes it active from the next cycle; a completion naming a warp that is not sleeping sets `ldc_err_o` for the next cycle only and changes no warp state.
- R9: A warp whose issued instruction carries the last-instruction flag finishes; in the cycle after the last live warp finishes, `retired_o` is 1 for one cycle and `busy_o` falls at the end of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| launch_i | input | 1 | Start a new block |
| launch_threads_i | input | 9 | Thread count of the block being launched |
| busy_o | output | 1 | A block is resident |
| wv_i | input | 8 | Per warp: next instruction has its operands |
| wcls_i | input | 16 | Per warp: 2-bit class of the next instruction, warp w at bits 2w+1:2w |
| wexit_i | input | 8 | Per warp: next instruction is the warp's last |
| port_rdy_i | input | 4 | Per class: execution port can accept an instruction |
| iss_valid_o | output | 1 | An instruction issues this cycle |
| iss_warp_o | output | 3 | Index of the issuing warp |
| iss_cls_o | output | 2 | Class of the issued instruction |
| ldc_valid_i | input | 1 | A load completion arrives |
| ldc_warp_i | input | 3 | Warp the completion belongs to |
| ldc_err_o | output | 1 | Completion named a warp that was not sleeping |
| retired_o | output | 1 | All warps of the block have finished |

## Verification
The issue logic is driven with all warps ready, with one warp asleep among ready ones, with a single ready warp whose port is blocked, with no operands at all, and with only an unlaunched warp ready. The all-ready pattern separates round-robin order from fixed priority, the sleeping pattern shows a parked warp being skipped without a lost cycle, and the blocked-port pattern separates port readiness from operand readiness. Completions are sent both to a sleeping warp and to an active one, to tell a wakeup from an error, and a final pass of last instructions shows retirement and the next launch using the full pool.

// File: rtl/wis_pkg.sv
package wis_pkg;
  localparam int WARP_LANES = 32;
  localparam int NUM_CLASSES = 4;

  typedef enum logic [1:0] {
    WS_IDLE   = 2'd0,
    WS_ACTIVE = 2'd1,
    WS_SLEEP  = 2'd2,
    WS_DONE   = 2'd3
  } wstate_e;

  localparam logic [1:0] CLS_INT  = 2'd0;
  localparam logic [1:0] CLS_FP   = 2'd1;
  localparam logic [1:0] CLS_LDST = 2'd2;
  localparam logic [1:0] CLS_SFU  = 2'd3;
endpackage

// File: rtl/wis_warp_slot.sv
module wis_warp_slot
  import wis_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    launch_en,
  input  logic    launch_live,
  input  logic    issue_en,
  input  logic    issue_exit,
  input  logic    issue_load,
  input  logic    wake_en,
  output wstate_e state_o
);

  wstate_e state_q;
  wstate_e state_d;
  logic    upd_en;

  always_comb begin
    state_d = state_q;
    if (launch_en) begin
      state_d = launch_live ? WS_ACTIVE : WS_IDLE;
    end else if (issue_en) begin
      if (issue_exit)      state_d = WS_DONE;
      else if (issue_load) state_d = WS_SLEEP;
    end else if (wake_en && state_q == WS_SLEEP) begin
      state_d = WS_ACTIVE;
    end
  end

  assign upd_en = launch_en | issue_en | wake_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state_q <= WS_IDLE;
    else if (upd_en) state_q <= state_d;
  end

  assign state_o = state_q;

  // R4: a parked warp stays parked until its completion arrives
  p_sleep_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WS_SLEEP && !wake_en && !launch_en) |=> (state_q == WS_SLEEP));

  // R8: a completion for a sleeping warp wakes it
  p_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WS_SLEEP && wake_en && !launch_en) |=> (state_q == WS_ACTIVE));

endmodule

// File: rtl/wis_rr_pick.sv
module wis_rr_pick #(
  parameter int N = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         req,
  output logic                 gnt_valid,
  output logic [$clog2(N)-1:0] gnt_idx
);

  localparam int IW = $clog2(N);

  logic [IW-1:0] last_q;

  always_comb begin
    gnt_valid = 1'b0;
    gnt_idx   = '0;
    for (int o = 1; o <= N; o++) begin
      if (!gnt_valid && req[(int'(last_q) + o) % N]) begin
        gnt_valid = 1'b1;
        gnt_idx   = IW'((int'(last_q) + o) % N);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         last_q <= IW'(N - 1);
    else if (gnt_valid) last_q <= gnt_idx;
  end

  // R5: any request yields a grant in the same cycle
  p_no_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> gnt_valid);

  // R3: a grant only goes to a requester
  p_gnt_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> req[gnt_idx]);

  // R6: with two or more requesters the previous winner does not win again
  p_rotate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && $past(gnt_valid) && $countones(req) >= 2) |-> (gnt_idx != $past(gnt_idx)));

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import wis_pkg::*;
#(
  parameter int NUM_WARPS = 8
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   launch_i,
  input  logic [$clog2(NUM_WARPS*WARP_LANES+1)-1:0] launch_threads_i,
  output logic                                   busy_o,
  input  logic [NUM_WARPS-1:0]                   wv_i,
  input  logic [2*NUM_WARPS-1:0]                 wcls_i,
  input  logic [NUM_WARPS-1:0]                   wexit_i,
  input  logic [NUM_CLASSES-1:0]                 port_rdy_i,
  output logic                                   iss_valid_o,
  output logic [$clog2(NUM_WARPS)-1:0]           iss_warp_o,
  output logic [1:0]                             iss_cls_o,
  input  logic                                   ldc_valid_i,
  input  logic [$clog2(NUM_WARPS)-1:0]           ldc_warp_i,
  output logic                                   ldc_err_o,
  output logic                                   retired_o
);

  localparam int WID_W   = $clog2(NUM_WARPS);
  localparam int THR_W   = $clog2(NUM_WARPS*WARP_LANES+1);
  localparam int LANE_SH = $clog2(WARP_LANES);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_s1, rst_s2, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end
  assign rst_n_s = rst_s2;

  wstate_e            slot_st [NUM_WARPS];
  logic [NUM_WARPS-1:0] req;
  logic [NUM_WARPS-1:0] live;
  logic [THR_W:0]     thr_round;
  logic [THR_W:0]     warp_cnt;
  logic               launch_acc;
  logic               retire;
  logic               busy_q, busy_d, busy_en;
  logic               err_q, err_d;

  assign launch_acc = launch_i & ~busy_q;
  assign thr_round  = {1'b0, launch_threads_i} + (THR_W+1)'(WARP_LANES - 1);
  assign warp_cnt   = thr_round >> LANE_SH;

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_slot
    logic [1:0] cls_w;
    assign cls_w = wcls_i[2*w +: 2];

    wis_warp_slot u_slot (
      .clk         (clk),
      .rst_n       (rst_n_s),
      .launch_en   (launch_acc),
      .launch_live ((THR_W+1)'(w) < warp_cnt),
      .issue_en    (iss_valid_o && iss_warp_o == WID_W'(w)),
      .issue_exit  (wexit_i[w]),
      .issue_load  (cls_w == CLS_LDST),
      .wake_en     (ldc_valid_i && ldc_warp_i == WID_W'(w)),
      .state_o     (slot_st[w])
    );

    assign req[w]  = (slot_st[w] == WS_ACTIVE) && wv_i[w] && port_rdy_i[cls_w];
    assign live[w] = (slot_st[w] == WS_ACTIVE) || (slot_st[w] == WS_SLEEP);
  end

  wis_rr_pick #(.N(NUM_WARPS)) u_pick (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .req       (req),
    .gnt_valid (iss_valid_o),
    .gnt_idx   (iss_warp_o)
  );

  assign iss_cls_o = wcls_i[{iss_warp_o, 1'b0} +: 2];

  // block occupancy
  assign retire  = busy_q & ~(|live);
  assign busy_en = launch_acc | retire;
  assign busy_d  = launch_acc;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)     busy_q <= 1'b0;
    else if (busy_en) busy_q <= busy_d;
  end

  // completion for a warp that is not parked
  assign err_d = ldc_valid_i && (slot_st[ldc_warp_i] != WS_SLEEP);

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) err_q <= 1'b0;
    else          err_q <= err_d;
  end

  assign busy_o    = busy_q;
  assign retired_o = retire;
  assign ldc_err_o = err_q;

  // R3: the issuing warp is active and has its operands
  p_iss_active_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    iss_valid_o |-> (slot_st[iss_warp_o] == WS_ACTIVE && wv_i[iss_warp_o]));

  // R7: never issue into a port that cannot take it
  p_port_rdy_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    iss_valid_o |-> port_rdy_i[iss_cls_o]);

  // R4: a load issue parks the warp
  p_load_sleep_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (iss_valid_o && iss_cls_o == CLS_LDST && !wexit_i[iss_warp_o])
      |=> (slot_st[$past(iss_warp_o)] == WS_SLEEP));

  // R8: stray completion flags an error in the next cycle
  p_err_flag_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ldc_valid_i && slot_st[ldc_warp_i] == WS_ACTIVE) |=> ldc_err_o);

  // R9: retirement ends the resident block
  p_retire_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    retired_o |=> (!busy_o && !retired_o));

  // R2: no warp is live while no block is resident
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    !busy_o |-> !iss_valid_o);

endmodule

// File: tb/sim_warp_issue_sched.sv
module sim_warp_issue_sched;
  localparam int NW = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       launch_i;
  logic [8:0] launch_threads_i;
  logic       busy_o;
  logic [7:0] wv_i;
  logic [15:0] wcls_i;
  logic [7:0] wexit_i;
  logic [3:0] port_rdy_i;
  logic       iss_valid_o;
  logic [2:0] iss_warp_o;
  logic [1:0] iss_cls_o;
  logic       ldc_valid_i;
  logic [2:0] ldc_warp_i;
  logic       ldc_err_o;
  logic       retired_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  warp_issue_sched #(.NUM_WARPS(NW)) u0 (
    .clk(clk), .rst_n(rst_n), .launch_i(launch_i), .launch_threads_i(launch_threads_i),
    .busy_o(busy_o), .wv_i(wv_i), .wcls_i(wcls_i), .wexit_i(wexit_i),
    .port_rdy_i(port_rdy_i), .iss_valid_o(iss_valid_o), .iss_warp_o(iss_warp_o),
    .iss_cls_o(iss_cls_o), .ldc_valid_i(ldc_valid_i), .ldc_warp_i(ldc_warp_i),
    .ldc_err_o(ldc_err_o), .retired_o(retired_o)
  );

  task automatic check(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // layout: req[50:47] wv[46:39] cls[38:23] exit[22:15] prdy[14:11]
  //         ldv[10] ldw[9:7] exp_v[6] exp_w[5:3] exp_c[2:1] exp_err[0]
  // Four warps resident (100 threads); class 2 = load/store, 3 = special.
  localparam int NROWS = 19;
  localparam logic [50:0] TBL [NROWS] = '{
    {4'd6, 8'hFF, 16'h0000, 8'h00, 4'hF, 1'b0, 3'd0, 1'b1, 3'd0, 2'd0, 1'b0}, // R6 first pick warp 0
    {4'd6, 8'hFF, 16'h0000, 8'h00, 4'hF, 1'b0, 3'd0, 1'b1, 3'd1, 2'd0, 1'b0}, // R6
    {4'd4, 8'hFF, 16'h0020, 8'h00, 4'hF, 1'b0, 3'd0, 1'b1, 3'd2, 2'd2, 1'b0}, // R4 warp 2 loads
    {4'd5, 8'hFF, 16'h0000, 8'h00, 4'hF, 1'b0, 3'd0, 1'b1, 3'd3, 2'd0, 1'b0}, // R5 no lost cycle
    {4'd6, 8'hFF, 16'h0000, 8'h00, 4'hF, 1'b0, 3'd0, 1'b1, 3'd0, 2'd0, 1'b0}, // R6 wrap
    {4'd6, 8'hFF, 16'h0000, 8'h00, 4'hF, 1'b0, 3'd0, 1'b1, 3'd1, 2'd0, 1'b0}, // R6
    {4'd4, 8'hFF, 16'h0000, 8'h00, 4'hF, 1'b1, 3'd2, 1'b1, 3'd3, 2'd0, 1'b0}, // R4 skip sleeper
    {4'd8, 8'h04, 16'h0000, 8'h00, 4'hF, 1'b0, 3'd0, 1'b1, 3'd2, 2'd0, 1'b0}, // R8 woken
    {4'd8, 8'hFF, 16'h0000, 8'h00, 4'hF, 1'b1, 3'd1, 1'b1, 3'd3, 2'd0, 1'b0}, // R8 stray completion
    {4'd8, 8'hFF, 16'h0000, 8'h00, 4'hF, 1'b0, 3'd0, 1'b1, 3'd0, 2'd0, 1'b1}, // R8 error flag
    {4'd7, 8'hFF, 16'h000C, 8'h00, 4'h7, 1'b0, 3'd0, 1'b1, 3'd2, 2'd0, 1'b0}, // R7 port blocked
    {4'd7, 8'h02, 16'h000C, 8'h00, 4'h7, 1'b0, 3'd0, 1'b0, 3'd0, 2'd0, 1'b0}, // R7 stall
    {4'd7, 8'h02, 16'h000C, 8'h00, 4'hF, 1'b0, 3'd0, 1'b1, 3'd1, 2'd3, 1'b0}, // R7 special issues
    {4'd3, 8'h00, 16'h0000, 8'h00, 4'hF, 1'b0, 3'd0, 1'b0, 3'd0, 2'd0, 1'b0}, // R3 no operands
    {4'd2, 8'h10, 16'h0000, 8'h00, 4'hF, 1'b0, 3'd0, 1'b0, 3'd0, 2'd0, 1'b0}, // R2 warp 4 not launched
    {4'd9, 8'hFF, 16'h0000, 8'hFF, 4'hF, 1'b0, 3'd0, 1'b1, 3'd2, 2'd0, 1'b0}, // R9 exits
    {4'd9, 8'hFF, 16'h0000, 8'hFF, 4'hF, 1'b0, 3'd0, 1'b1, 3'd3, 2'd0, 1'b0}, // R9
    {4'd9, 8'hFF, 16'h0000, 8'hFF, 4'hF, 1'b0, 3'd0, 1'b1, 3'd0, 2'd0, 1'b0}, // R9
    {4'd9, 8'hFF, 16'h0000, 8'hFF, 4'hF, 1'b0, 3'd0, 1'b1, 3'd1, 2'd0, 1'b0}  // R9 last warp
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1 actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; launch_i = 1'b0; launch_threads_i = '0;
    wv_i = 8'hFF; wcls_i = '0; wexit_i = '0; port_rdy_i = 4'hF;
    ldc_valid_i = 1'b0; ldc_warp_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    // R1: quiet after reset even with operands offered
    check("R1 busy", int'(busy_o), 0);
    check("R1 issue", int'(iss_valid_o), 0);
    check("R1 retired", int'(retired_o), 0);
    check("R1 error", int'(ldc_err_o), 0);

    // R2: 100 threads -> 4 warps
    @(negedge clk);
    wv_i = '0; launch_i = 1'b1; launch_threads_i = 9'd100;
    @(negedge clk);
    launch_i = 1'b1; launch_threads_i = 9'd256;  // ignored: busy
    #2;
    check("R2 busy after launch", int'(busy_o), 1);
    @(negedge clk);
    launch_i = 1'b0;

    for (int i = 0; i < NROWS; i++) begin
      logic [50:0] r;
      string tag;
      r = TBL[i];
      @(negedge clk);
      wv_i = r[46:39]; wcls_i = r[38:23]; wexit_i = r[22:15]; port_rdy_i = r[14:11];
      ldc_valid_i = r[10]; ldc_warp_i = r[9:7];
      #2;
      tag = $sformatf("R%0d row %0d", r[50:47], i);
      check({tag, " valid"}, int'(iss_valid_o), int'(r[6]));
      if (r[6]) begin
        check({tag, " warp"}, int'(iss_warp_o), int'(r[5:3]));
        check({tag, " class"}, int'(iss_cls_o), int'(r[2:1]));
      end
      check({tag, " error"}, int'(ldc_err_o), int'(r[0]));
    end

    // R9: retirement pulse after last finish
    @(negedge clk);
    ldc_valid_i = 1'b0;
    #2;
    check("R9 retired pulse", int'(retired_o), 1);
    check("R9 no issue when done", int'(iss_valid_o), 0);
    @(negedge clk);
    #2;
    check("R9 retired drops", int'(retired_o), 0);
    check("R9 busy drops", int'(busy_o), 0);

    // R2: full block of 256 threads uses all eight warps
    wv_i = '0; wexit_i = '0; wcls_i = '0;
    launch_i = 1'b1; launch_threads_i = 9'd256;
    @(negedge clk);
    launch_i = 1'b0;
    wv_i = 8'h80;
    #2;
    check("R2 warp 7 issues", int'(iss_valid_o), 1);
    check("R2 warp 7 index", int'(iss_warp_o), 7);
    @(negedge clk);
    wv_i = 8'hFF;
    #2;
    check("R6 wrap to warp 0", int'(iss_warp_o), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule